// File: doc/BRIEF.md
# Glitch-Free Gated Reference Clock Divider

This block takes the crystal reference clock and produces a divided clock on an output pin that can run an external microcontroller. A single select bit picks a ratio of four or eight. The output stays low until the oscillator reports a settled amplitude and the output is enabled. It starts and stops only on whole output periods, so no shortened pulse ever appears on the pin.

The oscillator-ready flag and the three configuration bits are treated as asynchronous. Each passes through a two-flop synchronizer in the reference domain before use. The block also drives an enable for the synthesizer and the other transmit circuits. A clock-only mode drops that enable and leaves the oscillator-to-pin path running. The active-low reset stands for power-down, and it forces both outputs low.

Top module: `refclk_divider`

## Requirements
- R1: With the select bit `div_fast_i` at 1, `clk_o` repeats every 4 reference cycles: 2 cycles high, then 2 cycles low.
- R2: With `div_fast_i` at 0, `clk_o` repeats every 8 reference cycles: 4 cycles high, then 4 cycles low.
- R3: After `out_en_i` goes to 0, `clk_o` settles low within one output period and stays low.
- R4: While `rst_n` is sampled low at a reference edge, `clk_o` and `synth_en_o` are 0 after that edge.
- R5: After reset, `clk_o` stays low for as long as either `osc_ready_i` or `out_en_i` is 0.
- R6: Once both `osc_ready_i` and `out_en_i` are 1, `clk_o` goes high on the third rising reference edge that samples them high, and starts with a full-length high phase.
- R7: When `out_en_i` or `osc_ready_i` drops while the output runs, the period in progress completes with full-length high and low phases before the output stops.
- R8: A change of `div_fast_i` while running takes effect only at a period boundary. Every pulse has the full length of either the old ratio or the new one, with equal high and low phases.
- R9: With `clk_only_i` at 1, `synth_en_o` is 0 from the third reference edge after the bit is sampled, and `clk_o` keeps running.
- R10: With `clk_only_i` at 0 and reset released, `synth_en_o` is 1 from the third reference edge after the bit is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Synchronous active-low power-down reset |
| osc_ready_i | input | 1 | Oscillator amplitude settled (asynchronous) |
| out_en_i | input | 1 | Enables the divided clock on `clk_o` (asynchronous) |
| div_fast_i | input | 1 | 1 selects divide by 4, 0 selects divide by 8 (asynchronous) |
| clk_only_i | input | 1 | 1 powers down everything except the oscillator-to-pin path (asynchronous) |
| clk_o | output | 1 | Divided, gated clock output |
| synth_en_o | output | 1 | Enable for the synthesizer and the other circuits |

## Verification
The bench builds the block with its default parameters: ratios of 4 and 8 and two synchronizer stages. With these values the start latency is exactly three reference edges, and both ratios can be exercised within a few hundred cycles. This covers the clean start, a disable in the middle of a high phase, a ratio switch at an arbitrary point in a period, and the entry into clock-only mode. Every pulse is measured, so a runt or a mixed-length pulse at any of these points is caught.

// File: rtl/refdiv_pkg.sv
// Package refdiv_pkg
// Shared types for the gated reference clock divider.
// Assumes: all fields are sampled in the reference clock domain.
package refdiv_pkg;

    // Asynchronous control bits, grouped so they can share one synchronizer.
    typedef struct packed {
        logic clk_only;   // 1: only the oscillator-to-pin path stays alive
        logic fast_sel;   // 1: divide by 4, 0: divide by 8
        logic out_en;     // 1: output pin allowed to toggle
        logic osc_rdy;    // 1: oscillator amplitude settled
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/refdiv_sync.sv
// Module refdiv_sync
// Multi-bit, multi-stage synchronizer for independent level signals.
// Assumes: every bit is a slow level whose bits need no coherence with one
// another, and STAGES is at least 2.
module refdiv_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    // Shift the raw bits through the stage chain; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/refdiv_core.sv
// Module refdiv_core
// Whole-period clock divider with a start/stop gate and two selectable ratios.
// Starts with a full high phase on the first edge that sees run_req. It
// re-checks run_req and the ratio only at the last count of a period, so
// every pulse it produces is complete.
// Assumes: run_req and fast_sel are already synchronous; SLOW_DIV >= FAST_DIV,
// and both are even and at least 2.
module refdiv_core #(
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    input  logic fast_sel,
    output logic clk_q
);

    localparam int CW = $clog2(SLOW_DIV);
    localparam logic [CW-1:0] FAST_HALF = CW'(FAST_DIV / 2);
    localparam logic [CW-1:0] SLOW_HALF = CW'(SLOW_DIV / 2);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_DIV - 1);
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_DIV - 1);

    logic          running;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic [CW-1:0] half_q;
    logic [CW-1:0] last_q;
    logic [CW-1:0] sel_half;
    logic [CW-1:0] sel_last;

    // Pick the phase length and the last count of the requested ratio.
    always_comb begin
        sel_half = fast_sel ? FAST_HALF : SLOW_HALF;
        sel_last = fast_sel ? FAST_LAST : SLOW_LAST;
        cnt_nxt  = cnt + 1'b1;
    end

    // Count within a period; start, stop or change ratio only at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            clk_q   <= 1'b0;
            half_q  <= SLOW_HALF;
            last_q  <= SLOW_LAST;
        end else if (!running) begin
            cnt <= '0;
            if (run_req) begin
                running <= 1'b1;
                clk_q   <= 1'b1;
                half_q  <= sel_half;
                last_q  <= sel_last;
            end else begin
                clk_q   <= 1'b0;
            end
        end else if (cnt == last_q) begin
            cnt <= '0;
            if (run_req) begin
                clk_q  <= 1'b1;
                half_q <= sel_half;
                last_q <= sel_last;
            end else begin
                running <= 1'b0;
                clk_q   <= 1'b0;
            end
        end else begin
            cnt   <= cnt_nxt;
            clk_q <= (cnt_nxt < half_q);
        end
    end

endmodule

// File: rtl/refdiv_mode.sv
// Module refdiv_mode
// Registers the enable for the synthesizer and the other transmit circuits.
// Assumes: clk_only arrives synchronized; rst_n low means power-down.
module refdiv_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_only,
    output logic synth_en
);

    // Enable the rest of the chip only in normal mode and out of power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synth_en <= 1'b0;
        end else begin
            synth_en <= ~clk_only;
        end
    end

endmodule

// File: rtl/refclk_divider.sv
// Module refclk_divider (top)
// Gated reference clock divider for an external clock pin. It synchronizes
// the asynchronous ready and configuration bits and runs the divided clock
// in whole periods while both ready and enable are high. It also drives
// the enable for the synthesizer according to clock-only mode.
// Assumes: clk_ref is a free-running crystal clock; rst_n is synchronous.
module refclk_divider #(
    parameter int FAST_DIV    = 4,
    parameter int SLOW_DIV    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic osc_ready_i,
    input  logic out_en_i,
    input  logic div_fast_i,
    input  logic clk_only_i,
    output logic clk_o,
    output logic synth_en_o
);

    import refdiv_pkg::*;

    ctrl_t raw_ctrl;
    ctrl_t sync_ctrl;
    logic  run_req;

    // Gather the asynchronous inputs into one word for the synchronizer.
    always_comb begin
        raw_ctrl.clk_only = clk_only_i;
        raw_ctrl.fast_sel = div_fast_i;
        raw_ctrl.out_en   = out_en_i;
        raw_ctrl.osc_rdy  = osc_ready_i;
    end

    refdiv_sync #(
        .W      (CTRL_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     (raw_ctrl),
        .q     (sync_ctrl)
    );

    // The output may run only when the oscillator is ready and the pin is enabled.
    assign run_req = sync_ctrl.osc_rdy & sync_ctrl.out_en;

    refdiv_core #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_core (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .run_req  (run_req),
        .fast_sel (sync_ctrl.fast_sel),
        .clk_q    (clk_o)
    );

    refdiv_mode u_mode (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .clk_only (sync_ctrl.clk_only),
        .synth_en (synth_en_o)
    );

endmodule

// File: rtl/refdiv_checker.sv
// Module refdiv_checker
// Protocol checks on the ports of refclk_divider, attached through bind.
// Assumes: the input-to-output latency of the mode path is LAT edges
// (two synchronizer stages plus one output register).
module refdiv_checker #(
    parameter int LAT = 3
) (
    input logic clk,
    input logic rst_n,
    input logic clk_only_i,
    input logic clk_o,
    input logic synth_en_o
);

    logic [3:0] warm_cnt;

    // Count the consecutive edges with reset released, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_cnt <= '0;
        end else if (warm_cnt != 4'hF) begin
            warm_cnt <= warm_cnt + 1'b1;
        end
    end

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (!clk_o && !synth_en_o)); // R4

    AST_HIGH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_o) |=> clk_o); // R7

    AST_LOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_o) |=> !clk_o); // R7

    AST_SYNTH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cnt >= 4'(LAT) && $past(clk_only_i, 3)) |-> !synth_en_o); // R9

    AST_SYNTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cnt >= 4'(LAT) && !$past(clk_only_i, 3)) |-> synth_en_o); // R10

endmodule

bind refclk_divider refdiv_checker u_chk (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .clk_only_i (clk_only_i),
    .clk_o      (clk_o),
    .synth_en_o (synth_en_o)
);

// File: tb/refclk_divider_tb.sv
// Bench refclk_divider_tb
// Scoreboard bench: the driver queues the expected phase length of coming
// pulses, and a monitor measures every pulse on clk_o and compares.
module refclk_divider_tb;

    logic clk_ref = 1'b0;
    logic rst_n = 1'b0;
    logic osc_ready_i = 1'b0;
    logic out_en_i = 1'b0;
    logic div_fast_i = 1'b0;
    logic clk_only_i = 1'b0;
    logic clk_o;
    logic synth_en_o;

    int checks = 0;
    int failures = 0;
    bit mon_en = 1'b0;
    bit done_run = 1'b0;

    int    exp_half_q[$];
    string exp_tag_q[$];

    always #5 clk_ref = ~clk_ref;

    refclk_divider u_dut (
        .clk_ref     (clk_ref),
        .rst_n       (rst_n),
        .osc_ready_i (osc_ready_i),
        .out_en_i    (out_en_i),
        .div_fast_i  (div_fast_i),
        .clk_only_i  (clk_only_i),
        .clk_o       (clk_o),
        .synth_en_o  (synth_en_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_pulses(input int half, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_half_q.push_back(half);
            exp_tag_q.push_back(tag);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk_ref);
    endtask

    // Hold-low check over a window: counts the cycles with clk_o high.
    task automatic expect_low(input int n, input string req);
        int highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk_ref);
            if (clk_o) highs++;
        end
        check(highs == 0, req, highs, 0);
    endtask

    // Monitor: measure each pulse, check its shape, pop the scoreboard.
    int  hi_len = 0;
    int  lo_len = 0;
    bit  judged = 1'b1;
    bit  prev_clk = 1'b0;
    always @(negedge clk_ref) begin
        if (!mon_en) begin
            hi_len = 0; lo_len = 0; judged = 1'b1; prev_clk = 1'b0;
        end else begin
            if (clk_o) begin
                if (!prev_clk) begin
                    if (hi_len > 0 && !judged)
                        check(1'b0, "R8 low phase cut short", lo_len, hi_len);
                    hi_len = 1; lo_len = 0; judged = 1'b0;
                end else begin
                    hi_len++;
                end
            end else if (hi_len > 0) begin
                lo_len++;
                if (lo_len == hi_len && !judged) begin
                    judged = 1'b1;
                    check(hi_len == 2 || hi_len == 4, "R8 pulse length", hi_len, 2);
                    if (exp_half_q.size() > 0) begin
                        int    eh;
                        string et;
                        eh = exp_half_q.pop_front();
                        et = exp_tag_q.pop_front();
                        check(hi_len == eh, et, hi_len, eh);
                    end
                end
            end
            prev_clk = clk_o;
        end
    end

    // Driver: stimulus sequence.
    initial begin
        cycles(4);
        check(!clk_o && !synth_en_o, "R4 reset state", {clk_o, synth_en_o}, 0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        cycles(6);
        check(synth_en_o, "R10 normal mode enable", synth_en_o, 1);

        out_en_i = 1'b1;
        div_fast_i = 1'b1;
        expect_low(20, "R5 held low without ready");

        // Clean start at divide by 4, with exact latency.
        push_pulses(2, 4, "R1 divide by 4");
        osc_ready_i = 1'b1;
        cycles(2);
        check(!clk_o, "R6 still low after two edges", clk_o, 0);
        cycles(1);
        check(clk_o, "R6 high on third edge", clk_o, 1);
        cycles(30);

        // Disable in the middle of a high phase.
        while (!clk_o) @(negedge clk_ref);
        push_pulses(2, 1, "R7 last pulse on disable");
        out_en_i = 1'b0;
        cycles(10);
        expect_low(20, "R3 held low when disabled");

        // Divide by 8.
        div_fast_i = 1'b0;
        cycles(3);
        push_pulses(4, 3, "R2 divide by 8");
        out_en_i = 1'b1;
        cycles(60);

        // Ratio switch at an arbitrary point in a period.
        cycles(3);
        div_fast_i = 1'b1;
        cycles(30);
        push_pulses(2, 3, "R8 new ratio in force");
        cycles(20);

        // Ready drop in the middle of a divide-by-8 high phase.
        div_fast_i = 1'b0;
        cycles(30);
        while (!clk_o) @(negedge clk_ref);
        cycles(1);
        push_pulses(4, 1, "R7 last pulse on ready drop");
        osc_ready_i = 1'b0;
        cycles(10);
        expect_low(20, "R5 held low after ready drop");

        // Clock-only mode: synthesizer off, clock still running.
        div_fast_i = 1'b1;
        clk_only_i = 1'b1;
        osc_ready_i = 1'b1;
        cycles(10);
        check(!synth_en_o, "R9 synth enable off", synth_en_o, 0);
        push_pulses(2, 3, "R9 clock runs in clock-only mode");
        cycles(20);
        clk_only_i = 1'b0;
        cycles(5);
        check(synth_en_o, "R10 synth enable back on", synth_en_o, 1);

        // Power-down while running.
        check(exp_half_q.size() == 0, "R1 all expected pulses seen", exp_half_q.size(), 0);
        mon_en = 1'b0;
        rst_n = 1'b0;
        cycles(1);
        check(!clk_o && !synth_en_o, "R4 power-down forces low", {clk_o, synth_en_o}, 0);
        cycles(3);
        check(!clk_o && !synth_en_o, "R4 power-down stays low", {clk_o, synth_en_o}, 0);

        done_run = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        if (!done_run) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule